// File: doc/BRIEF.md
# Processor Ready-Line Stepping Controller

This block drives the ready input of an 8-bit processor whose bus stalls only on read cycles. It looks at the opcode-fetch marker, the read/write line, a mode selection and a step request. From these it decides, cycle by cycle, whether to hold the ready line low. While ready is low on a read, the processor repeats that cycle with the same address on the bus. A write cycle cannot be frozen, so the controller never pulls ready low during one.

There are three uses. In instruction-step mode the processor stops at every opcode fetch. In cycle-step mode it stops at every read. Each step request lets exactly one cycle through, and the controller catches the processor again at the next stopping point. In run mode, steps are not used. Instead, a programmable wait count adds wait states to every read so that slow memory can be used. One processor cycle equals one clock of this block. The ready output is combinational from registered state and the current bus marker lines, so a stop can land in the same cycle in which the fetch marker rises.

Top module: `stepctl`

## Requirements
- R1: While `rst` is high, `rdy` is high. A synchronous reset clears any pending release and the wait counter.
- R2: The `mode` encoding is 2'b00 run, 2'b01 instruction step, 2'b10 cycle step. 2'b11 behaves as run.
- R3: In a cycle with `rw` = 0 (write), `rdy` is high in every mode.
- R4: In instruction-step mode, a read cycle with `sync` = 1 drives `rdy` low unless a release is active in that cycle.
- R5: In cycle-step mode, every read cycle drives `rdy` low unless a release is active in that cycle.
- R6: In a step mode, `step_req` high in cycle t makes a release active in cycle t+1 only. During that cycle `rdy` is high whatever the bus is doing.
- R7: In run mode, a read is held with `rdy` low for `wait_states` consecutive cycles and then released for one cycle. The count starts again after any cycle with `rdy` high or any write.
- R8: In run mode, `step_req` has no effect on `rdy`, neither in the same cycle nor later.
- R9: In instruction-step mode, read cycles with `sync` = 0 keep `rdy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per processor cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Stepping mode (see R2) |
| wait_states | input | WAIT_W (2) | Wait states added to each read in run mode |
| step_req | input | 1 | Request to let one cycle through |
| sync | input | 1 | High in opcode-fetch cycles |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| rdy | output | 1 | Ready to the processor; low stalls a read |

## Verification
Two functions can meet in the same cycle: a release granted by the previous step request, and a stopping point (a fetch read, or any read in cycle-step mode). The bench provokes this by issuing step requests on back-to-back cycles while the bus shows qualifying reads. It then judges that the release wins for exactly that cycle and that the stop returns in the following one. A second meeting is the release arriving on a write, where the release is consumed with no visible effect. Random mode switches with a run-mode wait count in flight also check that a half-counted wait restarts cleanly.

// File: rtl/stepctl_pkg.sv
package stepctl_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_INSTR   = 2'b01,
        MODE_CYCLE   = 2'b10,
        MODE_RUN_ALT = 2'b11
    } step_mode_e;

    typedef struct packed {
        logic fetch;
        logic rd;
    } bus_cyc_t;

    function automatic logic is_step_mode(step_mode_e m);
        return (m == MODE_INSTR) || (m == MODE_CYCLE);
    endfunction

    function automatic logic is_stop_point(step_mode_e m, bus_cyc_t b);
        logic hit;
        case (m)
            MODE_INSTR: hit = b.fetch & b.rd;
            MODE_CYCLE: hit = b.rd;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/stepctl_release.sv
module stepctl_release
    import stepctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  step_mode_e mode,
    input  logic       step_req,
    output logic       release_now
);
    logic pass_q;

    always_ff @(posedge clk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= step_req & is_step_mode(mode);
    end

    assign release_now = pass_q;
endmodule

// File: rtl/stepctl_wait.sv
module stepctl_wait
    import stepctl_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  step_mode_e        mode,
    input  logic [WAIT_W-1:0] limit,
    input  bus_cyc_t          bus,
    output logic              hold
);
    logic [WAIT_W-1:0] cnt_q;
    logic              run_mode;

    assign run_mode = !is_step_mode(mode);
    assign hold     = run_mode & bus.rd & (cnt_q < limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (hold) cnt_q <= cnt_q + 1'b1;
        else           cnt_q <= '0;
    end
endmodule

// File: rtl/stepctl.sv
module stepctl
    import stepctl_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [WAIT_W-1:0] wait_states,
    input  logic              step_req,
    input  logic              sync,
    input  logic              rw,
    output logic              rdy
);
    step_mode_e mode_e;
    bus_cyc_t   bus;
    logic       release_now;
    logic       wait_hold;
    logic       stop_hold;

    assign mode_e    = step_mode_e'(mode);
    assign bus.fetch = sync;
    assign bus.rd    = rw;

    stepctl_release u_rel (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .step_req   (step_req),
        .release_now(release_now)
    );

    stepctl_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_e),
        .limit(wait_states),
        .bus  (bus),
        .hold (wait_hold)
    );

    assign stop_hold = is_stop_point(mode_e, bus) & ~release_now;
    assign rdy       = rst | ~(stop_hold | wait_hold);
endmodule

// File: rtl/stepctl_chk.sv
module stepctl_chk #(
    parameter int WAIT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic [WAIT_W-1:0] wait_states,
    input logic              step_req,
    input logic              sync,
    input logic              rw,
    input logic              rdy
);
    p_reset_ready_r1: assert property (@(posedge clk) rst |-> rdy);

    p_write_free_r3: assert property (@(posedge clk) disable iff (rst)
        !rw |-> rdy);

    p_fetch_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && sync && rw && !$past(step_req)) |-> !rdy);

    p_read_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && rw && !$past(step_req)) |-> !rdy);

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(step_req && !rst && (mode == 2'b01 || mode == 2'b10))
         && (mode == 2'b01 || mode == 2'b10)) |-> rdy);

    p_no_wait_r7: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00 || mode == 2'b11) && wait_states == '0) |-> rdy);

    p_nonfetch_free_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !sync) |-> rdy);
endmodule

bind stepctl stepctl_chk #(.WAIT_W(WAIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .wait_states(wait_states),
    .step_req   (step_req),
    .sync       (sync),
    .rw         (rw),
    .rdy        (rdy)
);

// File: tb/sim_stepctl.sv
module sim_stepctl;
    localparam int WAIT_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode = 2'b00;
    logic [WAIT_W-1:0] wait_states = '0;
    logic              step_req = 1'b0;
    logic              sync = 1'b0;
    logic              rw = 1'b1;
    logic              rdy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit m_pass = 0;
    int m_wc = 0;

    always #10 clk = ~clk;

    stepctl #(.WAIT_W(WAIT_W)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .wait_states(wait_states),
        .step_req(step_req), .sync(sync), .rw(rw), .rdy(rdy)
    );

    function automatic bit f_run(logic [1:0] m);
        return (m == 2'b00) || (m == 2'b11);
    endfunction

    function automatic bit f_exp(bit r, logic [1:0] m, int wt, bit s, bit rd, bit ps, int wc);
        if (r) return 1'b1;
        if (!rd) return 1'b1;
        if (f_run(m)) return !(wc < wt);
        if (m == 2'b01) return !(s && !ps);
        return ps;
    endfunction

    function automatic string f_tag(bit r, logic [1:0] m, bit s, bit rd, bit ps, bit st);
        if (r) return "R1";
        if (!rd) return "R3";
        if (m == 2'b11) return "R2";
        if (m == 2'b00) return st ? "R8" : "R7";
        if (ps) return "R6";
        if (m == 2'b01) return s ? "R4" : "R9";
        return "R5";
    endfunction

    task automatic cyc(bit r, logic [1:0] m, int wt, bit st, bit s, bit rd);
        bit e;
        @(negedge clk);
        rst = r; mode = m; wait_states = wt[WAIT_W-1:0];
        step_req = st; sync = s; rw = rd;
        #2;
        e = f_exp(r, m, wt, s, rd, m_pass, m_wc);
        checks++;
        if (rdy !== e) begin
            errors++;
            $display("FAIL %s rdy actual=%b expected=%b mode=%0d sync=%b rw=%b",
                     f_tag(r, m, s, rd, m_pass, st), rdy, e, m, s, rd);
        end
        @(posedge clk);
        if (r) begin
            m_pass = 0; m_wc = 0;
        end else begin
            if (f_run(m) && rd && m_wc < wt) m_wc = m_wc + 1;
            else m_wc = 0;
            m_pass = st && !f_run(m);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset, a step request during reset is dropped
        cyc(1, 2'b10, 0, 1, 1, 1);
        cyc(1, 2'b10, 0, 0, 1, 1);
        // R4/R6: stop on fetch, step lets one cycle through, then stops again
        cyc(0, 2'b01, 0, 0, 1, 1);
        cyc(0, 2'b01, 0, 1, 1, 1);
        cyc(0, 2'b01, 0, 0, 1, 1);
        cyc(0, 2'b01, 0, 0, 1, 1);
        // R9: non-fetch reads pass in instruction step
        cyc(0, 2'b01, 0, 0, 0, 1);
        // R6 with back-to-back requests meeting stop points
        cyc(0, 2'b10, 0, 1, 0, 1);
        cyc(0, 2'b10, 0, 1, 0, 1);
        cyc(0, 2'b10, 0, 0, 0, 1);
        cyc(0, 2'b10, 0, 0, 0, 1);
        // R3: release lands on a write, consumed
        cyc(0, 2'b10, 0, 1, 0, 1);
        cyc(0, 2'b10, 0, 0, 0, 0);
        cyc(0, 2'b10, 0, 0, 0, 1);
        // R7: three wait states then release, then restart
        for (int i = 0; i < 5; i++) cyc(0, 2'b00, 3, 0, 0, 1);
        // R8: step in run mode ignored, wait 0
        cyc(0, 2'b00, 0, 1, 1, 1);
        cyc(0, 2'b00, 1, 0, 1, 1);
        cyc(0, 2'b00, 1, 0, 1, 1);
        // R2: mode 3 acts as run
        cyc(0, 2'b11, 2, 1, 1, 1);
        cyc(0, 2'b11, 2, 0, 1, 1);
        cyc(0, 2'b11, 2, 0, 1, 1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit r, st, s, rd;
            logic [1:0] m;
            int wt;
            r  = ($urandom % 50) == 0;
            m  = 2'(($urandom % 16 == 0) ? $urandom : mode);
            wt = ($urandom % 8 == 0) ? int'($urandom % 4) : int'(wait_states);
            st = ($urandom % 4) == 0;
            s  = ($urandom % 3) == 0;
            rd = ($urandom % 5) != 0;
            cyc(r, m, wt, st, s, rd);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule